// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns the system clock into time quanta and steps every bit on the bus through its segments. A programmable prescaler divides the clock into quanta. Each bit then runs through one synchronization quantum, a first phase segment and a second phase segment. The block strobes the sample point at the end of the first phase segment and the transmit point at the start of the synchronization quantum. It also delivers the bus value taken at the sample point, either as one sample or as a two-of-three vote over the last three quanta.

The receive line carries no clock, so the block aligns itself to edges on that line. While the bus is flagged idle, a recessive-to-dominant edge restarts the bit at once (hard synchronization). During a frame, an edge that arrives late lengthens the first phase segment and an edge that arrives early shortens the second one. The correction is capped by a programmable jump width, which is itself capped by both phase segments. Rising edges can be switched in or out as resynchronization sources. Edges are not used while the node itself drives a dominant bit, and only one correction is allowed per bit. Frame decoding and error handling belong to the surrounding controller.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_o` pulses for one clock every `brp_i` clocks; `brp_i` = 0 acts as 1. The sample and transmit strobes only follow a quantum pulse.
- R2: With no edges, a bit lasts 1 + `tseg1_i` + `tseg2_i` quanta. `txpt_o` pulses once per bit at the start of the synchronization quantum. `sample_o` pulses at the end of the first phase segment, `tseg2_i` quanta before `txpt_o` and never in the same cycle as it. Bits of 10 to 20 quanta are covered.
- R3: While `bus_idle_i` is 1, a falling edge (1 = recessive, 0 = dominant) on `rx_i` makes the quantum in which it is found the synchronization quantum. With `brp_i` = 1 and the default two synchronizer stages, if `rx_i` falls before clock edge 1, `sample_o` is first high after clock edge `tseg1_i` + 3, with `bit_o` = 0.
- R4: During a frame, an accepted edge found in the k-th quantum of the first phase segment (k counted from 1) lengthens that segment by min(k, jump width).
- R5: An accepted edge found in a quantum of the second phase segment, with m quanta of that segment left including the current one, shortens the bit by min(m, jump width). When m does not exceed the jump width, the next quantum is the first of the first phase segment. An edge in the synchronization quantum moves nothing.
- R6: The jump width in use is the smallest of `sjw_i`, `tseg1_i` and `tseg2_i`.
- R7: With `both_edges_i` = 0 only falling edges resynchronize and rising edges leave the timing unchanged; with `both_edges_i` = 1 both directions do.
- R8: Edges on `rx_i` leave the timing unchanged while `tx_dom_i` is 1.
- R9: After one edge has been accepted in a bit, further edges in that bit leave the timing unchanged.
- R10: With `triple_i` = 0, `bit_o` takes the synchronized line at the sample quantum. With `triple_i` = 1 it takes the majority of the synchronized line at the sample quantum and the two quanta before it. `bit_o` changes only in a cycle where `sample_o` is high.
- R11: During reset `tq_o`, `sample_o` and `txpt_o` are 0 and `bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw receive line, 1 recessive, 0 dominant |
| bus_idle_i | input | 1 | 1 while no frame is in progress; enables hard synchronization |
| tx_dom_i | input | 1 | 1 while this node drives a dominant bit |
| both_edges_i | input | 1 | 0: falling edges only resynchronize; 1: both edges |
| triple_i | input | 1 | 0: single sample; 1: majority of three |
| brp_i | input | 6 | Quantum length in clocks |
| tseg1_i | input | 5 | First phase segment in quanta (1 to 16) |
| tseg2_i | input | 4 | Second phase segment in quanta (1 to 8) |
| sjw_i | input | 3 | Jump width in quanta (1 to 4) |
| tq_o | output | 1 | One-clock pulse per quantum |
| sample_o | output | 1 | Sample point strobe |
| txpt_o | output | 1 | Transmit point strobe |
| bit_o | output | 1 | Bus value taken at the last sample point |

## Verification
A constant line at several prescaler and segment settings checks the nominal bit length and where the two strobes fall. A single falling edge on an idle bus checks the hard-synchronization latency. Single edges placed at known quanta before and after the sample point separate lengthening from shortening and show where the jump-width cap and the clamp by the phase segments take hold. Rising edges in both edge modes, edges under a dominant transmit, and two edges in one bit show that ignored edges move no strobe. One-clock and two-clock pulses placed around the sample point tell single sampling from the majority vote.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  // Segment of the bit currently being timed.
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tq_o
);

  logic [BRP_W-1:0] pc_q, pc_d, lim;
  logic             tick_q, tick_d;

  always_comb begin
    lim    = (brp_i == '0) ? '0 : brp_i - 1'b1;
    tick_d = (pc_q >= lim);
    pc_d   = tick_d ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      tick_q <= tick_d;
    end
  end

  assign tq_o = tick_q;

endmodule

// File: rtl/cbt_rx_front.sv
module cbt_rx_front
  import cbt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic tq_i,
  input  logic triple_i,
  output logic rise_o,
  output logic fall_o,
  output logic smp_val_o
);

  logic [STAGES-1:0] sync_q;
  logic              rx_s;
  logic              last_q, prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], rx_i};
      end
    end
  endgenerate

  assign rx_s = sync_q[STAGES-1];

  // Line value kept at the two previous quanta.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      prev_q <= 1'b1;
    end else if (tq_i) begin
      last_q <= rx_s;
      prev_q <= last_q;
    end
  end

  assign rise_o    = tq_i &  rx_s & ~last_q;
  assign fall_o    = tq_i & ~rx_s &  last_q;
  assign smp_val_o = triple_i ? maj3(prev_q, last_q, rx_s) : rx_s;

endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
  import cbt_pkg::*;
#(
  parameter int T1_W  = 5,
  parameter int T2_W  = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             smp_val_i,
  input  logic             bus_idle_i,
  input  logic             tx_dom_i,
  input  logic             both_edges_i,
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             txpt_o,
  output logic             bit_o
);

  localparam int CNT_W = ((T1_W > T2_W) ? T1_W : T2_W) + 1;

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ext_q, ext_d;
  logic [CNT_W-1:0] shr_q, shr_d;
  logic             used_q, used_d;
  logic             smp_q, smp_d;
  logic             txp_q, txp_d;
  logic             bit_q, bit_d;

  logic [CNT_W-1:0] t1w, t2w, sjw_eff, cnt_inc;
  logic [CNT_W-1:0] ext_n, shr_n, len1, len2, left;
  logic             edge_sel, hard_sync, resync;

  always_comb begin
    t1w     = CNT_W'(tseg1_i);
    t2w     = CNT_W'(tseg2_i);
    sjw_eff = CNT_W'(sjw_i);
    if (t1w < sjw_eff) sjw_eff = t1w;
    if (t2w < sjw_eff) sjw_eff = t2w;

    edge_sel  = fall_i | (both_edges_i & rise_i);
    hard_sync = bus_idle_i & fall_i;
    resync    = ~bus_idle_i & edge_sel & ~used_q & ~tx_dom_i;
    cnt_inc   = cnt_q + 1'b1;

    // Late edge: phase error is the quantum index inside TSEG1.
    ext_n = ext_q;
    if (resync && seg_q == SEG_PH1)
      ext_n = (cnt_inc < sjw_eff) ? cnt_inc : sjw_eff;
    len1 = t1w + ext_n;

    // Early edge: phase error is the TSEG2 quanta still to run.
    left  = (t2w > cnt_q) ? t2w - cnt_q : CNT_W'(1);
    shr_n = (resync && seg_q == SEG_PH2) ? sjw_eff : shr_q;
    len2  = (t2w > shr_n) ? t2w - shr_n : CNT_W'(1);

    seg_d  = seg_q;
    cnt_d  = cnt_q;
    ext_d  = ext_q;
    shr_d  = shr_q;
    used_d = used_q;
    smp_d  = 1'b0;
    txp_d  = 1'b0;
    bit_d  = bit_q;

    if (hard_sync) begin
      seg_d  = SEG_PH1;
      cnt_d  = '0;
      ext_d  = '0;
      shr_d  = '0;
      used_d = 1'b0;
    end else if (tq_i) begin
      case (seg_q)
        SEG_SYNC: begin
          seg_d = SEG_PH1;
          cnt_d = '0;
          if (resync) used_d = 1'b1;
        end
        SEG_PH1: begin
          if (resync) used_d = 1'b1;
          if (cnt_inc >= len1) begin
            seg_d = SEG_PH2;
            cnt_d = '0;
            ext_d = '0;
            smp_d = 1'b1;
            bit_d = smp_val_i;
          end else begin
            cnt_d = cnt_inc;
            ext_d = ext_n;
          end
        end
        SEG_PH2: begin
          if (resync && left <= sjw_eff) begin
            seg_d  = SEG_PH1;
            cnt_d  = '0;
            shr_d  = '0;
            used_d = 1'b0;
            txp_d  = 1'b1;
          end else if (cnt_inc >= len2) begin
            seg_d  = SEG_SYNC;
            cnt_d  = '0;
            shr_d  = '0;
            used_d = 1'b0;
            txp_d  = 1'b1;
          end else begin
            cnt_d  = cnt_inc;
            shr_d  = shr_n;
            used_d = used_q | resync;
          end
        end
        default: begin
          seg_d = SEG_SYNC;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      used_q <= 1'b0;
      smp_q  <= 1'b0;
      txp_q  <= 1'b0;
      bit_q  <= 1'b1;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      shr_q  <= shr_d;
      used_q <= used_d;
      smp_q  <= smp_d;
      txp_q  <= txp_d;
      bit_q  <= bit_d;
    end
  end

  assign sample_o = smp_q;
  assign txpt_o   = txp_q;
  assign bit_o    = bit_q;

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W    = 6,
  parameter int T1_W     = 5,
  parameter int T2_W     = 4,
  parameter int SJW_W    = 3,
  parameter int RX_SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic             tx_dom_i,
  input  logic             both_edges_i,
  input  logic             triple_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             tq_o,
  output logic             sample_o,
  output logic             txpt_o,
  output logic             bit_o
);

  logic [1:0] rsync_q;
  logic       rst_core_n;
  logic       tq;
  logic       rise, fall, smp_val;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_core_n),
    .brp_i (brp_i),
    .tq_o  (tq)
  );

  cbt_rx_front #(.STAGES(RX_SYNC)) u_front (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rx_i      (rx_i),
    .tq_i      (tq),
    .triple_i  (triple_i),
    .rise_o    (rise),
    .fall_o    (fall),
    .smp_val_o (smp_val)
  );

  cbt_bit_fsm #(.T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .tq_i         (tq),
    .rise_i       (rise),
    .fall_i       (fall),
    .smp_val_i    (smp_val),
    .bus_idle_i   (bus_idle_i),
    .tx_dom_i     (tx_dom_i),
    .both_edges_i (both_edges_i),
    .tseg1_i      (tseg1_i),
    .tseg2_i      (tseg2_i),
    .sjw_i        (sjw_i),
    .sample_o     (sample_o),
    .txpt_o       (txpt_o),
    .bit_o        (bit_o)
  );

  assign tq_o = tq;

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
  input logic clk,
  input logic rst_n,
  input logic tq_o,
  input logic sample_o,
  input logic txpt_o,
  input logic bit_o
);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && txpt_o));

  // R1
  sample_after_tq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> $past(tq_o));

  // R1
  txpt_after_tq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txpt_o |-> $past(tq_o));

  // R2
  txpt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txpt_o |=> !txpt_o);

  // R10
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_o) |-> sample_o);

endmodule

bind can_bit_timer cbt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tq_o     (tq_o),
  .sample_o (sample_o),
  .txpt_o   (txpt_o),
  .bit_o    (bit_o)
);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx, idle, txdom, both, triple;
  logic [5:0] brp;
  logic [4:0] tseg1;
  logic [3:0] tseg2;
  logic [2:0] sjw;
  logic       tq_o, sample_o, txpt_o, bit_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  can_bit_timer u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_i         (rx),
    .bus_idle_i   (idle),
    .tx_dom_i     (txdom),
    .both_edges_i (both),
    .triple_i     (triple),
    .brp_i        (brp),
    .tseg1_i      (tseg1),
    .tseg2_i      (tseg2),
    .sjw_i        (sjw),
    .tq_o         (tq_o),
    .sample_o     (sample_o),
    .txpt_o       (txpt_o),
    .bit_o        (bit_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_sample();
    int g = 0;
    do begin @(negedge clk); g++; end while (!sample_o && g < 2000);
  endtask

  task automatic count_txpt(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!txpt_o && n < 2000);
  endtask

  task automatic count_tq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tq_o && n < 2000);
  endtask

  // R11: reset values
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 tq_o in reset", int'(tq_o), 0);
    check("R11 sample_o in reset", int'(sample_o), 0);
    check("R11 txpt_o in reset", int'(txpt_o), 0);
    check("R11 bit_o in reset", int'(bit_o), 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // R1: quantum period
  task automatic t_prescale(input int b, input int exp, input string tag);
    int n;
    brp = 6'(b);
    repeat (10) @(negedge clk);
    count_tq(n);
    count_tq(n);
    check(tag, n, exp);
  endtask

  // R2: nominal bit length and strobe placement
  task automatic t_bitlen(input int b, input int t1, input int t2, input string tag);
    int n;
    brp = 6'(b); tseg1 = 5'(t1); tseg2 = 4'(t2);
    count_txpt(n); count_txpt(n); count_txpt(n);
    count_txpt(n);
    check({tag, " bit period"}, n, (1 + t1 + t2) * b);
    wait_sample();
    count_txpt(n);
    check({tag, " sample to txpt"}, n, t2 * b);
  endtask

  // R3: hard synchronization latency
  task automatic t_hard();
    int n = 0;
    brp = 6'd1; tseg1 = 5'd8; tseg2 = 4'd4; sjw = 3'd2;
    idle = 1'b1; rx = 1'b1;
    repeat (40) @(negedge clk);
    rx = 1'b0;
    forever begin
      @(negedge clk); n++;
      if ((n >= 3 && sample_o) || n > 200) break;
    end
    check("R3 hard sync latency", n, 8 + 3);
    check("R3 bit_o after hard sync", int'(bit_o), 0);
    idle = 1'b0;
  endtask

  // Sample-to-sample interval with up to two line changes at given offsets
  task automatic t_resync(input int w1, input logic v1, input int w2, input logic v2,
                          input int exp, input string tag);
    int n = 0;
    wait_sample();
    if (w1 == 0) rx = v1;
    forever begin
      @(negedge clk); n++;
      if (sample_o || n > 200) break;
      if (n == w1) rx = v1;
      if (n == w2) rx = v2;
    end
    check(tag, n, exp);
  endtask

  // R10: pulse around the sample point, timing frozen by tx_dom
  task automatic t_pulse(input int a, input int b, input logic tri_mode,
                         input int expbit, input string tag);
    int n = 0;
    triple = tri_mode;
    wait_sample();
    forever begin
      @(negedge clk); n++;
      if (sample_o || n > 200) break;
      if (n == a) rx = 1'b1;
      if (n == b) rx = 1'b0;
    end
    check({tag, " interval"}, n, 13);
    check({tag, " bit_o"}, int'(bit_o), expbit);
  endtask

  initial begin
    rx = 1'b1; idle = 1'b0; txdom = 1'b0; both = 1'b1; triple = 1'b0;
    brp = 6'd1; tseg1 = 5'd8; tseg2 = 4'd4; sjw = 3'd2;

    t_reset();

    t_prescale(3, 3, "R1 brp=3 tq period");
    t_prescale(1, 1, "R1 brp=1 tq period");
    t_prescale(0, 1, "R1 brp=0 tq period");

    t_bitlen(1, 8, 4, "R2 13tq brp1");
    t_bitlen(2, 15, 4, "R2 20tq brp2");
    t_bitlen(1, 6, 3, "R2 10tq brp1");

    t_hard();

    // Line is now 0, nominal bit 13 quanta, jump width 2
    t_resync(3, 1'b1, -1, 1'b0, 14, "R4 late edge e=1");
    t_resync(5, 1'b0, -1, 1'b0, 15, "R4 late edge e=3 capped");
    t_resync(0, 1'b1, -1, 1'b0, 11, "R5 early edge m=2 absorbed");
    sjw = 3'd1;
    t_resync(0, 1'b0, -1, 1'b0, 12, "R5 early edge m=2 jump 1");
    sjw = 3'd2;

    both = 1'b0;
    t_resync(3, 1'b1, -1, 1'b0, 13, "R7 rising ignored");
    t_resync(3, 1'b0, -1, 1'b0, 14, "R7 falling used");
    both = 1'b1;

    txdom = 1'b1;
    t_resync(3, 1'b1, -1, 1'b0, 13, "R8 edge under tx dominant");
    txdom = 1'b0;

    t_resync(3, 1'b0, 4, 1'b1, 14, "R9 second edge ignored");

    tseg2 = 4'd2; sjw = 3'd3;
    wait_sample();
    t_resync(3, 1'b0, -1, 1'b0, 13, "R6 jump clamped by tseg2");
    tseg2 = 4'd4; sjw = 3'd2;
    wait_sample();

    txdom = 1'b1;
    t_pulse(10, 11, 1'b0, 1, "R10 single sample one-quantum pulse");
    t_pulse(10, 11, 1'b1, 0, "R10 majority one-quantum pulse");
    t_pulse(9, 11, 1'b1, 1, "R10 majority two-quantum pulse");
    txdom = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule